// File: doc/BRIEF.md
# Integer to Binary64 Converter with Precision Select

This unit turns an integer, held in a 64-bit source word, into an IEEE 754 binary64 value. A two-bit type code says how to read the source. It can be a 32-bit value, signed or unsigned, taken from the low half of the word. It can also be a 64-bit value, signed or unsigned, using the whole word. A precision select picks how the significand is rounded: to the 53 bits of binary64, or to the 24 bits of binary32. A binary32-precision result is still delivered in binary64 format. Because the binary32 value is widened exactly, the low fraction bits of such a result are zero.

The output is registered, so a result appears one clock after its operands are presented. Three status bits are held in registers: inexact, fraction-rounded and fraction-inexact. They are rewritten only by conversions that can round. Those are every binary32-precision conversion and every 64-bit source converted at binary64 precision. A 32-bit source converted at binary64 precision is always exact and leaves the three status bits unchanged. The 5-bit class code is rewritten on every conversion.

Top module: `i2f_convert`

## Requirements
- R1: Type code 0 reads the source as signed 32-bit, 1 as unsigned 32-bit, 2 as signed 64-bit and 3 as unsigned 64-bit. The 32-bit types ignore source bits 63:32.
- R2: When the precision select is 0 and the type is 32-bit, the result is the exact binary64 value of the integer.
- R3: A conversion with precision select 0 and a 32-bit type leaves the inexact, fraction-rounded and fraction-inexact outputs at their previous values.
- R4: When the precision select is 0 and the type is 64-bit, the significand is rounded to 53 bits. Rounding mode 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 toward +infinity and 11 toward -infinity.
- R5: When the precision select is 1, every type is rounded to a 24-bit significand using the same mode encoding. The result is output as the equal binary64 value, so fraction bits 28:0 are zero.
- R6: Inexact is 1 when the rounded value differs from the integer, and 0 otherwise, for every conversion that updates status.
- R7: Fraction-rounded is 1 exactly when the magnitude was incremented by rounding. Fraction-inexact equals inexact.
- R8: The class code is 00010 for +0, 00100 for a positive normal value and 01000 for a negative normal value. It is taken from the result at the precision that was produced.
- R9: A zero source gives +0.0 (all 64 result bits zero) with class 00010 and no inexact.
- R10: The most negative signed 32-bit and 64-bit sources convert to -2^31 and -2^63 exactly.
- R11: Operands presented before a rising clock edge produce their result and class after that edge. While reset is active, the result and all three status bits are 0 and the class is 00010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | 64 | Integer source word |
| itype_i | input | 2 | Source type code |
| sp_sel_i | input | 1 | 1 selects binary32 precision, 0 binary64 |
| rmode_i | input | 2 | Rounding mode |
| result_o | output | 64 | Binary64 result |
| inexact_o | output | 1 | Inexact status |
| frac_rnd_o | output | 1 | Fraction-rounded status |
| frac_inx_o | output | 1 | Fraction-inexact status |
| class_o | output | 5 | Result class code |

## Verification
The assertions take for granted that the type, precision and mode inputs are never unknown once reset is released. They also take for granted that the inputs stay stable around each rising edge, since the hold and class checks compare registered outputs across consecutive edges. The stimulus drives every input on the falling edge, from the first cycle of reset onward, so no unknown value ever reaches a sampled edge. Random sources are shifted right by random amounts, which yields magnitudes across the whole exponent range. Directed ties and extreme values cover the rounding and negation corners.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

  typedef enum logic [1:0] {
    IT_S32 = 2'd0,
    IT_U32 = 2'd1,
    IT_S64 = 2'd2,
    IT_U64 = 2'd3
  } itype_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  localparam logic [4:0] CLS_PZERO = 5'b00010;
  localparam logic [4:0] CLS_PNORM = 5'b00100;
  localparam logic [4:0] CLS_NNORM = 5'b01000;

endpackage

// File: rtl/i2f_unpack.sv
module i2f_unpack #(
  parameter int W = 64
) (
  input  logic [W-1:0] src_i,
  input  logic [1:0]   itype_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  localparam int HALF = W / 2;

  logic         narrow;
  logic         signd;
  logic [W-1:0] ext;

  always_comb begin
    narrow = ~itype_i[1];
    signd  = ~itype_i[0];
    if (narrow)
      ext = signd ? {{HALF{src_i[HALF-1]}}, src_i[HALF-1:0]}
                  : {{HALF{1'b0}}, src_i[HALF-1:0]};
    else
      ext = src_i;
    neg_o = signd & ext[W-1];
    // two's complement negation in W bits: the most negative value maps onto
    // its own pattern, which read unsigned is the correct magnitude
    mag_o = neg_o ? (~ext + {{(W-1){1'b0}}, 1'b1}) : ext;
  end

endmodule

// File: rtl/i2f_norm.sv
module i2f_norm #(
  parameter int W   = 64,
  parameter int LZW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   mag_i,
  output logic [W-1:0]   norm_o,
  output logic [LZW-1:0] lz_o,
  output logic           zero_o
);

  always_comb begin
    lz_o = '0;
    for (int i = 0; i < W; i++) begin
      if (mag_i[i]) lz_o = LZW'(W - 1 - i);
    end
    zero_o = (mag_i == '0);
    norm_o = mag_i << lz_o;
  end

  // a nonzero magnitude is left-aligned so the rounder sees its leading one
  p_norm_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_o |-> norm_o[W-1]);

endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int W   = 64,
  parameter int P   = 53,
  parameter int EW  = 11,
  parameter int LZW = $clog2(W)
) (
  input  logic [W-1:0]   norm_i,
  input  logic [LZW-1:0] lz_i,
  input  logic           zero_i,
  input  logic           neg_i,
  input  logic [1:0]     rmode_i,
  output logic [W-1:0]   res_o,
  output logic           inexact_o,
  output logic           incr_o
);
  localparam int FW   = W - 1 - EW;
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic [P-1:0]  keep;
  logic          guard;
  logic          rbit;
  logic          sticky;
  logic          lost;
  logic          up;
  logic [P:0]    sum;
  logic          carry;
  logic [EW-1:0] bexp;
  logic [FW-1:0] frac;

  always_comb begin
    keep   = norm_i[W-1 -: P];
    guard  = norm_i[W-1-P];
    rbit   = norm_i[W-2-P];
    sticky = |norm_i[W-3-P:0];
    lost   = guard | rbit | sticky;
    unique case (rmode_e'(rmode_i))
      RM_NEAR: up = guard & (rbit | sticky | keep[0]);
      RM_ZERO: up = 1'b0;
      RM_UP:   up = ~neg_i & lost;
      default: up = neg_i & lost;
    endcase
    sum   = {1'b0, keep} + {{P{1'b0}}, up};
    carry = sum[P];
    bexp  = EW'(BIAS + W - 1 - 32'(lz_i) + 32'(carry));
    frac  = '0;
    if (!carry) frac[FW-1 -: P-1] = sum[P-2:0];
    if (zero_i) begin
      res_o     = '0;
      inexact_o = 1'b0;
      incr_o    = 1'b0;
    end else begin
      res_o     = {neg_i, bexp, frac};
      inexact_o = lost;
      incr_o    = up;
    end
  end

endmodule

// File: rtl/i2f_classify.sv
module i2f_classify
  import i2f_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] res_i,
  output logic [4:0]   cls_o
);

  always_comb begin
    if (res_i[W-2:0] == '0) cls_o = CLS_PZERO;
    else if (res_i[W-1])    cls_o = CLS_NNORM;
    else                    cls_o = CLS_PNORM;
  end

endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
  import i2f_pkg::*;
#(
  parameter int W    = 64,
  parameter int EW   = 11,
  parameter int DP_P = 53,
  parameter int SP_P = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  src_i,
  input  logic [1:0]    itype_i,
  input  logic          sp_sel_i,
  input  logic [1:0]    rmode_i,
  output logic [W-1:0]  result_o,
  output logic          inexact_o,
  output logic          frac_rnd_o,
  output logic          frac_inx_o,
  output logic [4:0]    class_o
);
  localparam int LZW    = $clog2(W);
  localparam int SP_PAD = DP_P - SP_P;

  logic           neg;
  logic [W-1:0]   mag;
  logic [W-1:0]   norm;
  logic [LZW-1:0] lz;
  logic           zero;
  logic [W-1:0]   rnd_res [2];
  logic           rnd_inx [2];
  logic           rnd_inc [2];
  logic [W-1:0]   res_sel;
  logic [4:0]     cls_sel;
  logic           upd_en;

  logic [W-1:0]   res_d, res_q;
  logic [4:0]     cls_d, cls_q;
  logic           xx_d, xx_q;
  logic           fr_d, fr_q;
  logic           fi_d, fi_q;

  i2f_unpack #(.W(W)) u_unpack (
    .src_i   (src_i),
    .itype_i (itype_i),
    .neg_o   (neg),
    .mag_o   (mag)
  );

  i2f_norm #(.W(W), .LZW(LZW)) u_norm (
    .clk    (clk),
    .rst_n  (rst_n),
    .mag_i  (mag),
    .norm_o (norm),
    .lz_o   (lz),
    .zero_o (zero)
  );

  // slot 0 rounds to binary64 precision, slot 1 to binary32 precision
  for (genvar g = 0; g < 2; g++) begin : g_rnd
    localparam int PREC = (g == 0) ? DP_P : SP_P;
    i2f_round #(.W(W), .P(PREC), .EW(EW), .LZW(LZW)) u_round (
      .norm_i    (norm),
      .lz_i      (lz),
      .zero_i    (zero),
      .neg_i     (neg),
      .rmode_i   (rmode_i),
      .res_o     (rnd_res[g]),
      .inexact_o (rnd_inx[g]),
      .incr_o    (rnd_inc[g])
    );
  end

  assign res_sel = rnd_res[sp_sel_i];

  i2f_classify #(.W(W)) u_cls (
    .res_i (res_sel),
    .cls_o (cls_sel)
  );

  // next-state
  always_comb begin
    upd_en = sp_sel_i | itype_i[1];
    res_d  = res_sel;
    cls_d  = cls_sel;
    xx_d   = xx_q;
    fr_d   = fr_q;
    fi_d   = fi_q;
    if (upd_en) begin
      xx_d = rnd_inx[sp_sel_i];
      fr_d = rnd_inc[sp_sel_i];
      fi_d = rnd_inx[sp_sel_i];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cls_q <= CLS_PZERO;
      xx_q  <= 1'b0;
      fr_q  <= 1'b0;
      fi_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      cls_q <= cls_d;
      xx_q  <= xx_d;
      fr_q  <= fr_d;
      fi_q  <= fi_d;
    end
  end

  assign result_o   = res_q;
  assign class_o    = cls_q;
  assign inexact_o  = xx_q;
  assign frac_rnd_o = fr_q;
  assign frac_inx_o = fi_q;

  p_exact_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_sel_i && !itype_i[1]) |-> !rnd_inx[0]);

  p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_sel_i | itype_i[1]) |=> $stable({xx_q, fr_q, fi_q}));

  p_sp_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_sel_i |=> (res_q[SP_PAD-1:0] == '0));

  p_rounded_inexact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fr_q |-> xx_q);

  p_zero_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q[W-2:0] == '0) |-> (cls_q == CLS_PZERO && !res_q[W-1]));

  p_neg_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_q[W-1] |-> (cls_q == CLS_NNORM));

endmodule

// File: tb/test_i2f_convert.sv
module test_i2f_convert;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src;
  logic [1:0]  ity;
  logic        sp;
  logic [1:0]  rm;
  logic [63:0] result;
  logic        xx, fr, fi;
  logic [4:0]  cls;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic exp_xx = 1'b0;
  logic exp_fr = 1'b0;

  always #4 clk = ~clk;

  i2f_convert i_i2f_convert (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src),
    .itype_i    (ity),
    .sp_sel_i   (sp),
    .rmode_i    (rm),
    .result_o   (result),
    .inexact_o  (xx),
    .frac_rnd_o (fr),
    .frac_inx_o (fi),
    .class_o    (cls)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  // {result[63:0], inexact, incremented, class[4:0]}
  function automatic logic [70:0] ref_cvt(input logic [63:0] s, input logic [1:0] t,
                                          input logic prec1, input logic [1:0] mode);
    logic neg, up;
    logic [63:0] mag, q, rem, half, frac;
    longint sv;
    int p, msb, sh, lpos;
    p = prec1 ? 24 : 53;
    case (t)
      2'd0: begin sv = longint'($signed(s[31:0])); neg = (sv < 0);
                  mag = neg ? 64'(-sv) : 64'(sv); end
      2'd1: begin neg = 1'b0; mag = {32'd0, s[31:0]}; end
      2'd2: begin neg = s[63]; mag = neg ? (64'd0 - s) : s; end
      default: begin neg = 1'b0; mag = s; end
    endcase
    if (mag == 64'd0) return {64'd0, 1'b0, 1'b0, 5'b00010};
    msb = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) msb = i;
    sh = msb + 1 - p;
    if (sh < 0) sh = 0;
    q    = mag >> sh;
    rem  = (sh == 0) ? 64'd0 : (mag & ((64'd1 << sh) - 64'd1));
    half = (sh == 0) ? 64'd0 : (64'd1 << (sh - 1));
    case (mode)
      2'd0: up = (rem > half) || (rem == half && rem != 64'd0 && q[0]);
      2'd1: up = 1'b0;
      2'd2: up = !neg && rem != 64'd0;
      default: up = neg && rem != 64'd0;
    endcase
    q = q + {63'd0, up};
    lpos = 0;
    for (int i = 0; i < 64; i++) if (q[i]) lpos = i;
    frac = q ^ (64'd1 << lpos);
    if (lpos <= 52) frac = frac << (52 - lpos);
    else            frac = frac >> (lpos - 52);
    return {neg, 11'(lpos + sh + 1023), frac[51:0], rem != 64'd0, up,
            neg ? 5'b01000 : 5'b00100};
  endfunction

  task automatic run(input logic [63:0] s, input logic [1:0] t, input logic prec1,
                     input logic [1:0] mode, input string tag);
    logic [70:0] e;
    string stag;
    @(negedge clk);
    src = s; ity = t; sp = prec1; rm = mode;
    e = ref_cvt(s, t, prec1, mode);
    if (prec1 || t[1]) begin
      exp_xx = e[6];
      exp_fr = e[5];
      stag = "R6";
    end else begin
      stag = "R3";
    end
    @(posedge clk);
    #1;
    chk(tag, "result", result, e[70:7]);
    chk("R8", "class", {59'd0, cls}, {59'd0, e[4:0]});
    chk(stag, "inexact", {63'd0, xx}, {63'd0, exp_xx});
    chk("R7", "rounded", {63'd0, fr}, {63'd0, exp_fr});
    chk("R7", "frac_inexact", {63'd0, fi}, {63'd0, exp_xx});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd2024));
    rst_n = 1'b0; src = '0; ity = '0; sp = 1'b0; rm = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset result", result, 64'd0);
    chk("R11", "reset class", {59'd0, cls}, {59'd0, 5'b00010});
    chk("R11", "reset status", {61'd0, xx, fr, fi}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    run(64'd0, 2'd2, 1'b0, 2'd0, "R9");
    run(64'd0, 2'd0, 1'b1, 2'd2, "R9");
    run(64'hDEAD_BEEF_FFFF_FFFF, 2'd0, 1'b0, 2'd0, "R1");
    run(64'hDEAD_BEEF_FFFF_FFFF, 2'd1, 1'b0, 2'd0, "R1");
    run(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'd0, "R1");
    run(64'h0000_0001_0000_0003, 2'd1, 1'b0, 2'd0, "R1");
    run(64'h0000_0000_8000_0000, 2'd0, 1'b0, 2'd0, "R10");
    run(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd0, "R10");
    run(64'h8000_0000_0000_0000, 2'd2, 1'b1, 2'd3, "R10");
    run(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd0, "R4");
    run(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd1, "R4");
    run(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd0, "R4");
    run(64'h0020_0000_0000_0003, 2'd3, 1'b0, 2'd0, "R4");
    run(64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'd2, "R4");
    run(64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'd3, "R4");
    run(64'h7FFF_FFFF, 2'd0, 1'b0, 2'd3, "R2");
    for (int m = 0; m < 4; m++) begin
      run(64'h0100_0001, 2'd1, 1'b1, 2'(m), "R5");
      run(64'hFEFF_FFFF, 2'd0, 1'b1, 2'(m), "R5");
      run(64'h0100_0003, 2'd0, 1'b1, 2'(m), "R5");
    end
    run(64'h0100_0001, 2'd1, 1'b1, 2'd2, "R6");
    run(64'h1234_5678, 2'd1, 1'b0, 2'd0, "R3");

    for (int k = 0; k < 800; k++) begin
      r = {$urandom, $urandom};
      if ($urandom % 2 == 0) r = r >> ($urandom % 64);
      ity = 2'($urandom % 4);
      if ($urandom % 3 == 0) run(r, 2'($urandom % 2), 1'b0, 2'($urandom % 4), "R2");
      else if ($urandom % 2 == 0) run(r, 2'($urandom % 4), 1'b1, 2'($urandom % 4), "R5");
      else run(r, 2'd2 + 2'($urandom % 2), 1'b0, 2'($urandom % 4), "R4");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule